// File: doc/BRIEF.md
# Standby Mode Wakeup Controller

This controller moves a small processor core into a deep idle state and brings it back out. Software requests idle with a single control write. That write carries a two-bit mode field, a stop bit and three request masks. While the core is idle, the controller drops the clock enables for the CPU, the PLL, the flash and the general peripherals. The main oscillator and the peripherals clocked from the subclock keep running.

Wakeup can come from two non-maskable sources: the pin and the watchdog. It can also come from eight external interrupt inputs and a parameterised set of internal peripheral requests. Each class can be masked. Any of four reset sources also ends idle. When a request ends idle, the controller loads a programmable setup counter and restores the pre-idle PLL state. It re-enables the CPU, flash and peripheral clocks only after the count runs out.

Ending idle and acknowledging the request are separate decisions. A request ranked below the handler currently in service ends idle but gets no acknowledge, so it stays pending at its source. A non-maskable request, or one ranked above the handler in service, ends idle and is acknowledged with a one-cycle pulse that carries its identifier.

Top module: `standby_wake_ctrl`

## Requirements
- R1: A control write made in normal state with mode field equal to 2'b10 and stop bit 1 puts the block in idle at the next clock edge, and the stored stop bit reads 0 from then on. A write with stop 1 and any other mode value leaves the block in normal state and stores stop 1. A write with mode 2'b10 and stop 0 does not enter idle.
- R2: Status encoding is 2'b00 normal, 2'b01 idle and 2'b10 setup-wait. In idle, the CPU, flash, general-peripheral and PLL enables are 0, while the oscillator and subclock-peripheral enables stay 1. In normal state, the CPU, flash and peripheral enables are 1.
- R3: In idle, any unmasked request ends idle at the next edge and moves the block to setup-wait. The requests are the non-maskable pin, the non-maskable watchdog, any external input or any internal request.
- R4: Mask bit 0 blocks the non-maskable pin, mask bit 1 blocks the watchdog request, and mask bit 2 blocks all external and internal requests. A masked request never ends idle.
- R5: Request identifiers are 0 for the non-maskable pin, 1 for the watchdog, 2 to 9 for external inputs 0 to 7, and 10 upward for internal request 0 upward. The lowest identifier present wins. A maskable request has rank equal to its identifier minus 2, and a smaller rank means a higher priority. The winner is acknowledged if it is non-maskable, if no handler is in service, or if its rank is below the in-service level. Otherwise it is not acknowledged.
- R6: Setup-wait lasts setup_init+1 cycles, and then the block returns to normal. During setup-wait, the PLL enable equals the PLL setting captured at idle entry.
- R7: Any reset-source input returns the block to normal at the next edge from idle or setup-wait. It clears the mode field and the stop bit, and no acknowledge is issued.
- R8: The acknowledge is high for exactly one cycle, the first cycle of setup-wait. Its identifier is valid in that cycle.
- R9: Control writes outside the normal state are ignored, so the stored mode field does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| ctl_we_i | input | 1 | Control write strobe |
| ctl_mode_i | input | 2 | Mode field written |
| ctl_stop_i | input | 1 | Stop bit written |
| ctl_mask_i | input | 3 | Mask bits written (0 pin, 1 watchdog, 2 maskable) |
| pll_cfg_i | input | 1 | Software PLL on/off setting |
| setup_init_i | input | CNT_W | Setup-wait count loaded on release |
| nmi_pin_i | input | 1 | Non-maskable pin request |
| nmi_wdt_i | input | 1 | Non-maskable watchdog request |
| ext_req_i | input | NUM_EXT | External interrupt requests |
| int_req_i | input | NUM_INT | Internal peripheral requests |
| rst_src_i | input | NUM_RST | Reset sources (pin, watchdog, low voltage, clock monitor) |
| svc_active_i | input | 1 | A handler is in service |
| svc_level_i | input | PW | Rank of the handler in service |
| osc_en_o | output | 1 | Main oscillator enable |
| sub_clk_en_o | output | 1 | Subclock peripheral enable |
| cpu_clk_en_o | output | 1 | CPU clock enable |
| flash_clk_en_o | output | 1 | Flash clock enable |
| per_clk_en_o | output | 1 | General peripheral clock enable |
| pll_en_o | output | 1 | PLL enable |
| status_o | output | 2 | State: 00 normal, 01 idle, 10 setup-wait |
| mode_o | output | 2 | Stored mode field |
| stop_o | output | 1 | Stored stop bit |
| ack_o | output | 1 | Acknowledge pulse |
| ack_id_o | output | IDW | Identifier of the acknowledged request |

## Verification
The bench exercises the entry decode. A design that enters on any stop write, or that keeps the stop bit set, is caught on the status and stop outputs. It then wakes the block with a request ranked below the in-service level. A design that acknowledges every waking request shows a spurious pulse. It also wakes the block with simultaneous requests of mixed class, where a wrong winner shows up in the identifier. It counts setup-wait cycles to catch an off-by-one release and changes the PLL setting during idle to expose a controller that fails to restore the captured state. Finally, it fires a reset source together with a request, which catches a design that acknowledges during a reset or fails to clear the mode field.

// File: rtl/standby_pkg.sv
package standby_pkg;
   typedef enum logic [1:0] {
      ST_NORMAL = 2'b00,
      ST_IDLE   = 2'b01,
      ST_SETUP  = 2'b10
   } sb_state_e;

   localparam logic [1:0] MODE_IDLE = 2'b10;
   localparam int MASK_PIN = 0;
   localparam int MASK_WDT = 1;
   localparam int MASK_MSK = 2;
endpackage

// File: rtl/wake_arbiter.sv
module wake_arbiter #(
   parameter int NUM_EXT = 8,
   parameter int NUM_INT = 4,
   localparam int NM  = NUM_EXT + NUM_INT,
   localparam int IDW = $clog2(NM + 2),
   localparam int PW  = $clog2(NM + 1)
) (
   input  logic               clk_i,
   input  logic               rst_ni,
   input  logic               nmi_pin_i,
   input  logic               nmi_wdt_i,
   input  logic [NUM_EXT-1:0] ext_req_i,
   input  logic [NUM_INT-1:0] int_req_i,
   input  logic [2:0]         mask_i,
   input  logic               svc_active_i,
   input  logic [PW-1:0]      svc_level_i,
   output logic               wake_o,
   output logic [IDW-1:0]     win_id_o,
   output logic               win_ack_o
);
   import standby_pkg::*;

   generate
      if (NUM_EXT < 1) begin : g_bad_ext
         $error("wake_arbiter: NUM_EXT must be at least 1");
      end
      if (NUM_INT < 1) begin : g_bad_int
         $error("wake_arbiter: NUM_INT must be at least 1");
      end
   endgenerate

   logic nmi_p, nmi_w;
   logic [NM-1:0] req_m;

   assign nmi_p = nmi_pin_i & ~mask_i[MASK_PIN];
   assign nmi_w = nmi_wdt_i & ~mask_i[MASK_WDT];

   generate
      for (genvar g = 0; g < NM; g++) begin : g_req
         if (g < NUM_EXT) begin : g_ext
            assign req_m[g] = ext_req_i[g] & ~mask_i[MASK_MSK];
         end else begin : g_int
            assign req_m[g] = int_req_i[g-NUM_EXT] & ~mask_i[MASK_MSK];
         end
      end
   endgenerate

   logic          mk_found;
   logic [PW-1:0] mk_rank;

   always_comb begin
      mk_found = 1'b0;
      mk_rank  = '0;
      for (int i = NM - 1; i >= 0; i--) begin
         if (req_m[i]) begin
            mk_found = 1'b1;
            mk_rank  = PW'(i);
         end
      end
   end

   always_comb begin
      win_id_o  = '0;
      win_ack_o = 1'b0;
      if (nmi_p) begin
         win_id_o  = IDW'(0);
         win_ack_o = 1'b1;
      end else if (nmi_w) begin
         win_id_o  = IDW'(1);
         win_ack_o = 1'b1;
      end else if (mk_found) begin
         win_id_o  = IDW'(mk_rank) + IDW'(2);
         win_ack_o = !svc_active_i || (mk_rank < svc_level_i);
      end
   end

   assign wake_o = nmi_p | nmi_w | mk_found;

   AST_MASKED_NEVER_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (mask_i[MASK_MSK] && wake_o) |-> (win_id_o < IDW'(2))); // R4
   AST_PIN_BEATS_ALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (nmi_pin_i && !mask_i[MASK_PIN]) |-> (win_ack_o && win_id_o == '0)); // R5
endmodule

// File: rtl/setup_timer.sv
module setup_timer #(
   parameter int CNT_W = 8
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             clr_i,
   input  logic             load_i,
   input  logic [CNT_W-1:0] load_val_i,
   input  logic             run_i,
   output logic             zero_o
);
   generate
      if (CNT_W < 1) begin : g_bad_w
         $error("setup_timer: CNT_W must be at least 1");
      end
   endgenerate

   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)          cnt_q <= '0;
      else if (clr_i)       cnt_q <= '0;
      else if (load_i)      cnt_q <= load_val_i;
      else if (run_i && cnt_q != '0) cnt_q <= cnt_q - 1'b1;
   end

   assign zero_o = (cnt_q == '0);

   AST_CNT_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (run_i && !zero_o && !load_i && !clr_i) |=> (cnt_q == $past(cnt_q) - 1'b1)); // R6
   AST_LOAD_TAKES: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (load_i && !clr_i) |=> (cnt_q == $past(load_val_i))); // R6
endmodule

// File: rtl/standby_wake_ctrl.sv
module standby_wake_ctrl #(
   parameter int NUM_EXT = 8,
   parameter int NUM_INT = 4,
   parameter int NUM_RST = 4,
   parameter int CNT_W   = 8,
   localparam int NM  = NUM_EXT + NUM_INT,
   localparam int IDW = $clog2(NM + 2),
   localparam int PW  = $clog2(NM + 1)
) (
   input  logic               clk_i,
   input  logic               rst_ni,
   input  logic               ctl_we_i,
   input  logic [1:0]         ctl_mode_i,
   input  logic               ctl_stop_i,
   input  logic [2:0]         ctl_mask_i,
   input  logic               pll_cfg_i,
   input  logic [CNT_W-1:0]   setup_init_i,
   input  logic               nmi_pin_i,
   input  logic               nmi_wdt_i,
   input  logic [NUM_EXT-1:0] ext_req_i,
   input  logic [NUM_INT-1:0] int_req_i,
   input  logic [NUM_RST-1:0] rst_src_i,
   input  logic               svc_active_i,
   input  logic [PW-1:0]      svc_level_i,
   output logic               osc_en_o,
   output logic               sub_clk_en_o,
   output logic               cpu_clk_en_o,
   output logic               flash_clk_en_o,
   output logic               per_clk_en_o,
   output logic               pll_en_o,
   output logic [1:0]         status_o,
   output logic [1:0]         mode_o,
   output logic               stop_o,
   output logic               ack_o,
   output logic [IDW-1:0]     ack_id_o
);
   import standby_pkg::*;

   generate
      if (NUM_RST < 1) begin : g_bad_rst
         $error("standby_wake_ctrl: NUM_RST must be at least 1");
      end
   endgenerate

   sb_state_e      state_q;
   logic [1:0]     mode_q;
   logic           stop_q;
   logic [2:0]     mask_q;
   logic           pll_saved_q;
   logic           ack_q;
   logic [IDW-1:0] ack_id_q;

   logic           rst_any, wake, win_ack, setup_zero, enter, wake_idle;
   logic [IDW-1:0] win_id;

   assign rst_any   = |rst_src_i;
   assign enter     = (state_q == ST_NORMAL) && ctl_we_i &&
                      (ctl_mode_i == MODE_IDLE) && ctl_stop_i;
   assign wake_idle = (state_q == ST_IDLE) && wake && !rst_any;

   wake_arbiter #(.NUM_EXT(NUM_EXT), .NUM_INT(NUM_INT)) u_arb (
      .clk_i        (clk_i),
      .rst_ni       (rst_ni),
      .nmi_pin_i    (nmi_pin_i),
      .nmi_wdt_i    (nmi_wdt_i),
      .ext_req_i    (ext_req_i),
      .int_req_i    (int_req_i),
      .mask_i       (mask_q),
      .svc_active_i (svc_active_i),
      .svc_level_i  (svc_level_i),
      .wake_o       (wake),
      .win_id_o     (win_id),
      .win_ack_o    (win_ack)
   );

   setup_timer #(.CNT_W(CNT_W)) u_tmr (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .clr_i      (rst_any),
      .load_i     (wake_idle),
      .load_val_i (setup_init_i),
      .run_i      (state_q == ST_SETUP),
      .zero_o     (setup_zero)
   );

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         state_q     <= ST_NORMAL;
         mode_q      <= 2'b00;
         stop_q      <= 1'b0;
         mask_q      <= 3'b000;
         pll_saved_q <= 1'b0;
      end else if (rst_any) begin
         state_q <= ST_NORMAL;
         mode_q  <= 2'b00;
         stop_q  <= 1'b0;
      end else begin
         unique case (state_q)
            ST_NORMAL: begin
               if (ctl_we_i) begin
                  mode_q <= ctl_mode_i;
                  mask_q <= ctl_mask_i;
                  stop_q <= enter ? 1'b0 : ctl_stop_i;
               end
               if (enter) begin
                  state_q     <= ST_IDLE;
                  pll_saved_q <= pll_cfg_i;
               end
            end
            ST_IDLE: begin
               if (wake) state_q <= ST_SETUP;
            end
            ST_SETUP: begin
               if (setup_zero) state_q <= ST_NORMAL;
            end
            default: state_q <= ST_NORMAL;
         endcase
      end
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         ack_q    <= 1'b0;
         ack_id_q <= '0;
      end else begin
         ack_q    <= wake_idle && win_ack;
         ack_id_q <= win_id;
      end
   end

   always_comb begin
      osc_en_o       = 1'b1;
      sub_clk_en_o   = 1'b1;
      cpu_clk_en_o   = (state_q == ST_NORMAL);
      flash_clk_en_o = (state_q == ST_NORMAL);
      per_clk_en_o   = (state_q == ST_NORMAL);
      unique case (state_q)
         ST_IDLE:  pll_en_o = 1'b0;
         ST_SETUP: pll_en_o = pll_saved_q;
         default:  pll_en_o = pll_cfg_i;
      endcase
   end

   assign status_o = state_q;
   assign mode_o   = mode_q;
   assign stop_o   = stop_q;
   assign ack_o    = ack_q;
   assign ack_id_o = ack_id_q;

   AST_STOP_SELF_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (status_o == ST_IDLE) |-> !stop_o); // R1
   AST_IDLE_GATES: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (status_o == ST_IDLE) |-> (!cpu_clk_en_o && !flash_clk_en_o && !per_clk_en_o &&
                                 !pll_en_o && osc_en_o && sub_clk_en_o)); // R2
   AST_MASKED_STAYS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (state_q == ST_IDLE && !rst_any && !wake) |=> (state_q == ST_IDLE)); // R4
   AST_SETUP_EXIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (state_q == ST_SETUP && setup_zero && !rst_any) |=> (state_q == ST_NORMAL)); // R6
   AST_RESET_ABORT: assert property (@(posedge clk_i) disable iff (!rst_ni)
      rst_any |=> (state_q == ST_NORMAL && mode_q == 2'b00 && !stop_q && !ack_o)); // R7
   AST_ACK_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ack_o |=> !ack_o); // R8
   AST_ACK_AFTER_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ack_o |-> (status_o == ST_SETUP && $past(state_q) == ST_IDLE)); // R8
   AST_WRITE_IGNORED: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (state_q != ST_NORMAL && !rst_any) |=> $stable(mode_q)); // R9
endmodule

// File: tb/tb_standby_wake_ctrl.sv
module tb_standby_wake_ctrl;
   localparam int CLK_PERIOD = 10;
   localparam int NUM_EXT = 8;
   localparam int NUM_INT = 4;
   localparam int NUM_RST = 4;
   localparam int CNT_W = 8;
   localparam int IDW = 4;
   localparam int PW = 4;
   localparam int SETUP_N = 3;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic ctl_we = 1'b0;
   logic [1:0] ctl_mode = 2'b00;
   logic ctl_stop = 1'b0;
   logic [2:0] ctl_mask = 3'b000;
   logic pll_cfg = 1'b1;
   logic [CNT_W-1:0] setup_init = CNT_W'(SETUP_N);
   logic nmi_pin = 1'b0, nmi_wdt = 1'b0;
   logic [NUM_EXT-1:0] ext_req = '0;
   logic [NUM_INT-1:0] int_req = '0;
   logic [NUM_RST-1:0] rst_src = '0;
   logic svc_active = 1'b0;
   logic [PW-1:0] svc_level = '0;
   logic osc_en, sub_en, cpu_en, flash_en, per_en, pll_en, stop_o, ack;
   logic [1:0] status, mode_o;
   logic [IDW-1:0] ack_id;

   int checks = 0;
   int errors = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   standby_wake_ctrl #(.NUM_EXT(NUM_EXT), .NUM_INT(NUM_INT), .NUM_RST(NUM_RST),
                       .CNT_W(CNT_W)) dut (
      .clk_i(clk), .rst_ni(rst_n), .ctl_we_i(ctl_we), .ctl_mode_i(ctl_mode),
      .ctl_stop_i(ctl_stop), .ctl_mask_i(ctl_mask), .pll_cfg_i(pll_cfg),
      .setup_init_i(setup_init), .nmi_pin_i(nmi_pin), .nmi_wdt_i(nmi_wdt),
      .ext_req_i(ext_req), .int_req_i(int_req), .rst_src_i(rst_src),
      .svc_active_i(svc_active), .svc_level_i(svc_level),
      .osc_en_o(osc_en), .sub_clk_en_o(sub_en), .cpu_clk_en_o(cpu_en),
      .flash_clk_en_o(flash_en), .per_clk_en_o(per_en), .pll_en_o(pll_en),
      .status_o(status), .mode_o(mode_o), .stop_o(stop_o), .ack_o(ack),
      .ack_id_o(ack_id));

   task automatic chk(input string tag, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic clear_reqs();
      nmi_pin = 0; nmi_wdt = 0; ext_req = '0; int_req = '0; rst_src = '0;
   endtask

   // drive a control write; returns at the negedge after it took effect
   task automatic wr(input logic [1:0] m, input logic s, input logic [2:0] k);
      @(negedge clk);
      ctl_we = 1; ctl_mode = m; ctl_stop = s; ctl_mask = k;
      @(negedge clk);
      ctl_we = 0;
   endtask

   task automatic wait_normal();
      for (int i = 0; i < 20 && status != 2'b00; i++) @(negedge clk);
   endtask

   task automatic t_reset();
      chk("R2 reset status", status, 0);
      chk("R2 reset cpu en", cpu_en, 1);
      chk("R8 reset ack", ack, 0);
      chk("R1 reset stop", stop_o, 0);
   endtask

   task automatic t_entry();
      wr(2'b01, 1, 3'b000);
      chk("R1 wrong mode stays normal", status, 0);
      chk("R1 stop stored", stop_o, 1);
      wr(2'b10, 0, 3'b000);
      chk("R1 stop 0 no entry", status, 0);
      pll_cfg = 1;
      wr(2'b10, 1, 3'b000);
      chk("R1 enter idle", status, 1);
      chk("R1 stop self-clears", stop_o, 0);
      chk("R2 cpu off", cpu_en, 0);
      chk("R2 flash off", flash_en, 0);
      chk("R2 periph off", per_en, 0);
      chk("R2 pll off", pll_en, 0);
      chk("R2 osc on", osc_en, 1);
      chk("R2 subclock on", sub_en, 1);
   endtask

   task automatic t_ignore_write();
      wr(2'b00, 1, 3'b111);
      chk("R9 mode kept in idle", mode_o, 2);
      chk("R9 still idle", status, 1);
      chk("R9 stop not stored", stop_o, 0);
   endtask

   task automatic t_wake_ext();
      pll_cfg = 0;
      svc_active = 0;
      ext_req[3] = 1;
      @(negedge clk);
      ext_req = '0;
      chk("R3 ext wakes", status, 2);
      chk("R8 ack pulse", ack, 1);
      chk("R5 ext3 id", ack_id, 5);
      chk("R6 pll restored", pll_en, 1);
      @(negedge clk);
      chk("R8 ack one cycle", ack, 0);
      chk("R6 setup k2", status, 2);
      @(negedge clk); @(negedge clk);
      chk("R6 setup k4", status, 2);
      chk("R6 cpu off in setup", cpu_en, 0);
      @(negedge clk);
      chk("R6 normal after N+1", status, 0);
      chk("R2 cpu back on", cpu_en, 1);
      pll_cfg = 1;
   endtask

   task automatic t_low_prio();
      wr(2'b10, 1, 3'b000);
      svc_active = 1; svc_level = 4'd2;
      ext_req[5] = 1;
      @(negedge clk);
      clear_reqs();
      chk("R5 low prio wakes", status, 2);
      chk("R5 low prio no ack", ack, 0);
      wait_normal();
   endtask

   task automatic t_high_prio();
      wr(2'b10, 1, 3'b000);
      svc_active = 1; svc_level = 4'd2;
      ext_req[1] = 1; ext_req[5] = 1; int_req[0] = 1;
      @(negedge clk);
      clear_reqs();
      chk("R5 high prio ack", ack, 1);
      chk("R5 high prio id", ack_id, 3);
      wait_normal();
   endtask

   task automatic t_nmi();
      wr(2'b10, 1, 3'b000);
      svc_active = 1; svc_level = 4'd0;
      nmi_wdt = 1; ext_req[0] = 1;
      @(negedge clk);
      clear_reqs();
      chk("R5 nmi ack in handler", ack, 1);
      chk("R5 wdt id", ack_id, 1);
      wait_normal();
   endtask

   task automatic t_internal();
      wr(2'b10, 1, 3'b000);
      svc_active = 0;
      int_req[2] = 1;
      @(negedge clk);
      clear_reqs();
      chk("R3 internal wakes", status, 2);
      chk("R5 internal id", ack_id, 12);
      chk("R5 internal ack", ack, 1);
      wait_normal();
   endtask

   task automatic t_masks();
      wr(2'b10, 1, 3'b011);
      nmi_pin = 1; nmi_wdt = 1;
      @(negedge clk); @(negedge clk);
      chk("R4 nmi masked", status, 1);
      ext_req[2] = 1;
      @(negedge clk);
      clear_reqs();
      chk("R4 unmasked ext wakes", status, 2);
      chk("R4 unmasked id", ack_id, 4);
      wait_normal();
      wr(2'b10, 1, 3'b111);
      nmi_pin = 1; nmi_wdt = 1; ext_req = '1; int_req = '1;
      @(negedge clk); @(negedge clk);
      chk("R4 all masked", status, 1);
      chk("R4 no ack when masked", ack, 0);
      clear_reqs();
   endtask

   task automatic t_reset_abort();
      // block is idle with all masks set
      rst_src[3] = 1; nmi_pin = 1;
      @(negedge clk);
      clear_reqs();
      chk("R7 reset to normal", status, 0);
      chk("R7 mode cleared", mode_o, 0);
      chk("R7 no ack", ack, 0);
      wr(2'b10, 1, 3'b000);
      nmi_pin = 1;
      @(negedge clk);
      nmi_pin = 0;
      chk("R3 nmi pin wakes", status, 2);
      rst_src[0] = 1;
      @(negedge clk);
      clear_reqs();
      chk("R7 reset from setup", status, 0);
      chk("R7 stop cleared", stop_o, 0);
   endtask

   initial begin
      #(CLK_PERIOD * 50000);
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      t_reset();
      t_entry();
      t_ignore_write();
      t_wake_ext();
      t_low_prio();
      t_high_prio();
      t_nmi();
      t_internal();
      t_masks();
      t_reset_abort();
      repeat (2) @(negedge clk);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule